// File: doc/BRIEF.md
# Memory-Reference Instruction Executor

This block executes the memory-reference group of a 16-bit accumulator machine: load accumulator, store accumulator, increment and skip if zero, decrement and skip if zero, jump, and jump to subroutine. It receives an opcode byte and a displacement byte while idle. It decodes the addressing mode and indirect flag from fixed opcode fields and forms the effective address. It then performs the needed reads and writes over a request/acknowledge memory port. At the end it retires the instruction by updating the four accumulators and the program counter.

Two kinds of event are left to logic outside the block. Page-zero subroutine calls whose displacement lies in a reserved high range are not executed. Instead the block raises a trap pulse that carries the displacement. A non-indirect PC-relative store raises a restart pulse, so that instruction words already fetched ahead are fetched again.

Control is one state machine with six named states:

| State | Role |
|---|---|
| S_IDLE | Accepts an instruction. |
| S_PTR | Reads the indirect pointer. |
| S_LOAD | Reads the operand. |
| S_STORE | Writes memory. |
| S_RETIRE | Updates registers and pulses `done`. |
| S_TRAP | Pulses `trap` and `done`. |

The transitions are as follows:

| From | Condition | To |
|---|---|---|
| S_IDLE | Opcode outside the group | S_RETIRE |
| S_IDLE | Trapped call | S_TRAP |
| S_IDLE | Indirect flag set | S_PTR |
| S_IDLE | Otherwise | The operation's first state |
| S_PTR | `ack` | The operation's first state |
| S_LOAD | `ack`, load | S_RETIRE |
| S_LOAD | `ack`, increment or decrement | S_STORE |
| S_STORE | `ack` | S_RETIRE |
| S_RETIRE | Always | S_IDLE |
| S_TRAP | Always | S_IDLE |

The operation's first state is S_RETIRE for a jump or a call, S_LOAD for a load, increment or decrement, and S_STORE for a store.

Top module: `mref_exec`

## Requirements
- R1: After reset the program counter and all four accumulators read 0, `instr_ready` is 1, and `mem_req` and `done` are 0.
- R2: The opcode classes, in octal, are as follows. 000–007 is jump, 010–017 is call, 020–027 is increment-skip and 030–037 is decrement-skip. 040–077 is load and 100–137 is store. Opcodes 140–377 retire with PC+1 and no memory access. Opcode bit 2 is the indirect flag. Bits [1:0] select the mode: 0 is page zero (displacement zero-extended), 1 is PC plus the sign-extended displacement, 2 is AC2 plus the sign-extended displacement, and 3 is AC3 plus the sign-extended displacement.
- R3: When the indirect flag is set, one extra read is made at the computed address, and the word read becomes the effective address.
- R4: A load writes the memory word at the effective address into the accumulator selected by opcode bits [4:3], and the PC advances by 1.
- R5: A store writes the accumulator selected by opcode bits [4:3] to the effective address, and the PC advances by 1.
- R6: Increment-skip writes back the word plus 1, and decrement-skip writes back the word minus 1. The PC advances by 2 when the written value is 0 and by 1 otherwise.
- R7: A jump loads the PC with the effective address.
- R8: A call loads AC3 with the old PC+1 and the PC with the effective address. The address is formed from AC3's old value.
- R9: A direct page-zero call with displacement 0300–0377 is trapped, and so is an indirect page-zero call with displacement 0340–0377. A trapped call makes no memory access, changes no register, and pulses `trap` together with `done`, with `trap_disp` equal to the displacement.
- R10: `restart` pulses together with `done` only for a non-indirect PC-relative store.
- R11: `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold steady until `mem_ack`, and `mem_req` is low while the block is idle.
- R12: `done` is a single-cycle pulse per instruction. The instruction inputs are taken only while `instr_ready` is high, and input presented during execution has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction present |
| instr_op | input | 8 | Opcode byte |
| instr_disp | input | 8 | Displacement byte |
| instr_ready | output | 1 | Block idle, instruction accepted |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | W | Word address |
| mem_wdata | output | W | Write data |
| mem_rdata | input | W | Read data, valid with ack |
| mem_ack | input | 1 | Access completes this cycle |
| pc | output | W | Program counter |
| ac0 | output | W | Accumulator 0 |
| ac1 | output | W | Accumulator 1 |
| ac2 | output | W | Accumulator 2 |
| ac3 | output | W | Accumulator 3 |
| done | output | 1 | Instruction retired (pulse) |
| trap | output | 1 | Call diverted to runtime (pulse) |
| trap_disp | output | 8 | Displacement of trapped call |
| restart | output | 1 | Prefetch restart request (pulse) |

## Verification
A wrong state or a wrong route through the machine shows up at the ports within one instruction. There are several ways it can appear:
- The number of memory requests is wrong, or a write strobe appears where none belongs.
- `done` arrives at the wrong time.
- `trap` or `restart` appears on the wrong opcode.
- A register or memory word holds the wrong value in the idle cycle right after `done`.

Because an accumulator or the PC value feeds the next address computation, a bad register value also corrupts the addressing of the following instruction.

// File: rtl/mref_pkg.sv
package mref_pkg;
    typedef enum logic [2:0] {
        CL_JMP, CL_JSR, CL_ISZ, CL_DSZ, CL_LDA, CL_STA, CL_NOP
    } op_class_e;

    typedef enum logic [1:0] {
        AM_ZERO, AM_PCREL, AM_AC2, AM_AC3
    } addr_mode_e;

    typedef enum logic [2:0] {
        S_IDLE, S_PTR, S_LOAD, S_STORE, S_RETIRE, S_TRAP
    } state_e;
endpackage

// File: rtl/mref_decode.sv
module mref_decode
    import mref_pkg::*;
#(
    parameter logic [7:0] TRAP_DIR_LO = 8'hC0,
    parameter logic [7:0] TRAP_IND_LO = 8'hE0
) (
    input  logic [7:0] op,
    input  logic [7:0] disp,
    output op_class_e  cls,
    output logic       ind,
    output addr_mode_e mode,
    output logic [1:0] acs,
    output logic       trap_hit
);
    always_comb begin
        unique case (op[7:5])
            3'b000: begin
                unique case (op[4:3])
                    2'b00:   cls = CL_JMP;
                    2'b01:   cls = CL_JSR;
                    2'b10:   cls = CL_ISZ;
                    default: cls = CL_DSZ;
                endcase
            end
            3'b001:  cls = CL_LDA;
            3'b010:  cls = CL_STA;
            default: cls = CL_NOP;
        endcase
        ind  = op[2];
        mode = addr_mode_e'(op[1:0]);
        acs  = op[4:3];
        trap_hit = (cls == CL_JSR) && (mode == AM_ZERO) &&
                   (ind ? (disp >= TRAP_IND_LO) : (disp >= TRAP_DIR_LO));
    end
endmodule

// File: rtl/mref_agen.sv
module mref_agen
    import mref_pkg::*;
#(
    parameter int W = 16
) (
    input  addr_mode_e     mode,
    input  logic [7:0]     disp,
    input  logic [W-1:0]   pc,
    input  logic [W-1:0]   base2,
    input  logic [W-1:0]   base3,
    output logic [W-1:0]   ea
);
    localparam int EXT = W - 8;

    logic [W-1:0] zext, sext;
    assign zext = {{EXT{1'b0}}, disp};
    assign sext = {{EXT{disp[7]}}, disp};

    always_comb begin
        unique case (mode)
            AM_ZERO:  ea = zext;
            AM_PCREL: ea = pc + sext;
            AM_AC2:   ea = base2 + sext;
            default:  ea = base3 + sext;
        endcase
    end
endmodule

// File: rtl/mref_ctrl.sv
module mref_ctrl
    import mref_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       instr_valid,
    input  logic       mem_ack,
    input  op_class_e  live_cls,
    input  logic       live_ind,
    input  logic       live_trap,
    input  op_class_e  q_cls,
    input  logic       q_ind,
    input  addr_mode_e q_mode,
    output logic       accept,
    output logic       ptr_ack,
    output logic       load_ack,
    output logic       retire,
    output logic       instr_ready,
    output logic       mem_req,
    output logic       mem_we,
    output logic       done,
    output logic       trap,
    output logic       restart
);
    state_e state_q, state_d;

    function automatic state_e first_state(op_class_e c);
        state_e s;
        unique case (c)
            CL_LDA, CL_ISZ, CL_DSZ: s = S_LOAD;
            CL_STA:                 s = S_STORE;
            default:                s = S_RETIRE;
        endcase
        return s;
    endfunction

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (instr_valid) begin
                    if (live_cls == CL_NOP)  state_d = S_RETIRE;
                    else if (live_trap)      state_d = S_TRAP;
                    else if (live_ind)       state_d = S_PTR;
                    else                     state_d = first_state(live_cls);
                end
            end
            S_PTR:    if (mem_ack) state_d = first_state(q_cls);
            S_LOAD:   if (mem_ack) state_d = (q_cls == CL_LDA) ? S_RETIRE : S_STORE;
            S_STORE:  if (mem_ack) state_d = S_RETIRE;
            S_RETIRE: state_d = S_IDLE;
            S_TRAP:   state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        instr_ready = 1'b0;
        mem_req     = 1'b0;
        mem_we      = 1'b0;
        done        = 1'b0;
        trap        = 1'b0;
        restart     = 1'b0;
        accept      = 1'b0;
        ptr_ack     = 1'b0;
        load_ack    = 1'b0;
        retire      = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                instr_ready = 1'b1;
                accept      = instr_valid;
            end
            S_PTR: begin
                mem_req = 1'b1;
                ptr_ack = mem_ack;
            end
            S_LOAD: begin
                mem_req  = 1'b1;
                load_ack = mem_ack;
            end
            S_STORE: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
            end
            S_RETIRE: begin
                done    = 1'b1;
                retire  = 1'b1;
                restart = (q_cls == CL_STA) && (q_mode == AM_PCREL) && !q_ind;
            end
            S_TRAP: begin
                done = 1'b1;
                trap = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/mref_exec.sv
module mref_exec
    import mref_pkg::*;
#(
    parameter int         W           = 16,
    parameter logic [7:0] TRAP_DIR_LO = 8'hC0,
    parameter logic [7:0] TRAP_IND_LO = 8'hE0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         instr_valid,
    input  logic [7:0]   instr_op,
    input  logic [7:0]   instr_disp,
    output logic         instr_ready,
    output logic         mem_req,
    output logic         mem_we,
    output logic [W-1:0] mem_addr,
    output logic [W-1:0] mem_wdata,
    input  logic [W-1:0] mem_rdata,
    input  logic         mem_ack,
    output logic [W-1:0] pc,
    output logic [W-1:0] ac0,
    output logic [W-1:0] ac1,
    output logic [W-1:0] ac2,
    output logic [W-1:0] ac3,
    output logic         done,
    output logic         trap,
    output logic [7:0]   trap_disp,
    output logic         restart
);
    localparam int         NAC     = 4;
    localparam logic [W-1:0] ONE   = W'(1);
    localparam logic [W-1:0] TWO   = W'(2);
    localparam logic [W-1:0] MINUS1 = {W{1'b1}};

    op_class_e  live_cls, q_cls;
    logic       live_ind, live_trap, q_ind;
    addr_mode_e live_mode, q_mode;
    logic [1:0] live_acs, q_acs;
    logic [7:0] disp_q;

    logic [W-1:0] pc_q;
    logic [W-1:0] ac_q [NAC];
    logic [W-1:0] ea_live, ea_q, data_q;
    logic         accept, ptr_ack, load_ack, retire;

    mref_decode #(.TRAP_DIR_LO(TRAP_DIR_LO), .TRAP_IND_LO(TRAP_IND_LO)) u_dec (
        .op       (instr_op),
        .disp     (instr_disp),
        .cls      (live_cls),
        .ind      (live_ind),
        .mode     (live_mode),
        .acs      (live_acs),
        .trap_hit (live_trap)
    );

    mref_agen #(.W(W)) u_agen (
        .mode  (live_mode),
        .disp  (instr_disp),
        .pc    (pc_q),
        .base2 (ac_q[2]),
        .base3 (ac_q[3]),
        .ea    (ea_live)
    );

    mref_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .instr_valid (instr_valid),
        .mem_ack     (mem_ack),
        .live_cls    (live_cls),
        .live_ind    (live_ind),
        .live_trap   (live_trap),
        .q_cls       (q_cls),
        .q_ind       (q_ind),
        .q_mode      (q_mode),
        .accept      (accept),
        .ptr_ack     (ptr_ack),
        .load_ack    (load_ack),
        .retire      (retire),
        .instr_ready (instr_ready),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .done        (done),
        .trap        (trap),
        .restart     (restart)
    );

    // Instruction fields and address/operand registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_cls  <= CL_NOP;
            q_ind  <= 1'b0;
            q_mode <= AM_ZERO;
            q_acs  <= '0;
            disp_q <= '0;
            ea_q   <= '0;
            data_q <= '0;
        end else begin
            if (accept) begin
                q_cls  <= live_cls;
                q_ind  <= live_ind;
                q_mode <= live_mode;
                q_acs  <= live_acs;
                disp_q <= instr_disp;
                ea_q   <= ea_live;
            end
            if (ptr_ack) ea_q <= mem_rdata;
            if (load_ack) begin
                unique case (q_cls)
                    CL_ISZ:  data_q <= mem_rdata + ONE;
                    CL_DSZ:  data_q <= mem_rdata + MINUS1;
                    default: data_q <= mem_rdata;
                endcase
            end
        end
    end

    // Program counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else if (retire) begin
            unique case (q_cls)
                CL_JMP, CL_JSR: pc_q <= ea_q;
                CL_ISZ, CL_DSZ: pc_q <= pc_q + ((data_q == '0) ? TWO : ONE);
                default:        pc_q <= pc_q + ONE;
            endcase
        end
    end

    // Accumulator file
    for (genvar i = 0; i < NAC; i++) begin : g_ac
        logic ld_hit, link_hit;
        assign ld_hit   = retire && (q_cls == CL_LDA) && (q_acs == 2'(i));
        assign link_hit = retire && (q_cls == CL_JSR) && (i == NAC - 1);
        always_ff @(posedge clk) begin
            if (!rst_n)        ac_q[i] <= '0;
            else if (ld_hit)   ac_q[i] <= data_q;
            else if (link_hit) ac_q[i] <= pc_q + ONE;
        end
    end

    assign mem_addr  = ea_q;
    assign mem_wdata = (q_cls == CL_STA) ? ac_q[q_acs] : data_q;
    assign trap_disp = disp_q;
    assign pc  = pc_q;
    assign ac0 = ac_q[0];
    assign ac1 = ac_q[1];
    assign ac2 = ac_q[2];
    assign ac3 = ac_q[3];
endmodule

// File: rtl/mref_exec_chk.sv
module mref_exec_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         instr_valid,
    input logic         instr_ready,
    input logic         mem_req,
    input logic         mem_we,
    input logic [W-1:0] mem_addr,
    input logic [W-1:0] mem_wdata,
    input logic         mem_ack,
    input logic         done,
    input logic         trap,
    input logic         restart
);
    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) &&
                                   $stable(mem_we) && $stable(mem_wdata)));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        instr_ready |-> !mem_req);

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R12
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_ready && instr_valid) |=> !instr_ready);

    // R9
    trap_nomem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> (done && !mem_req && !restart));

    // R10
    restart_after_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |-> (done && $past(mem_req && mem_we && mem_ack)));
endmodule

bind mref_exec mref_exec_chk #(.W(W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .instr_ready (instr_ready),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_ack     (mem_ack),
    .done        (done),
    .trap        (trap),
    .restart     (restart)
);

// File: tb/tb_mref_exec.sv
module tb_mref_exec;
    localparam int W = 16;
    localparam int MW = 1024;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         instr_valid = 1'b0;
    logic [7:0]   instr_op = '0;
    logic [7:0]   instr_disp = '0;
    logic         instr_ready, mem_req, mem_we, done, trap, restart;
    logic [W-1:0] mem_addr, mem_wdata, pc, ac0, ac1, ac2, ac3;
    logic [W-1:0] mem_rdata = '0;
    logic         mem_ack = 1'b0;
    logic [7:0]   trap_disp;

    int checks = 0;
    int failures = 0;
    int lat = 0;

    logic [W-1:0] mem     [MW];
    logic [W-1:0] exp_mem [MW];
    logic [W-1:0] m_pc;
    logic [W-1:0] m_ac [4];

    always #4 clk = ~clk;

    mref_exec dut (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_op(instr_op),
        .instr_disp(instr_disp), .instr_ready(instr_ready), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack), .pc(pc), .ac0(ac0), .ac1(ac1),
        .ac2(ac2), .ac3(ac3), .done(done), .trap(trap), .trap_disp(trap_disp),
        .restart(restart)
    );

    task automatic chk(input string tag, input string what, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Memory responder: ack after lat idle cycles, one ack per access
    initial begin
        int wcnt = 0;
        forever begin
            @(negedge clk);
            if (mem_ack) mem_ack = 1'b0;
            else if (mem_req) begin
                if (wcnt >= lat) begin
                    wcnt = 0;
                    mem_ack = 1'b1;
                    mem_rdata = mem[mem_addr[9:0]];
                    if (mem_we) mem[mem_addr[9:0]] = mem_wdata;
                end else wcnt++;
            end
        end
    end

    task automatic set_word(input int a, input logic [W-1:0] v);
        mem[a] = v;
        exp_mem[a] = v;
    endtask

    // Execute one instruction on DUT and on the arithmetic model, then compare
    task automatic run(input logic [7:0] op, input logic [7:0] d);
        logic [W-1:0] ea, sx, v;
        logic ind, e_trap, e_rs, g_trap, g_rs;
        logic [1:0] md, a;
        string tag;
        int n, mism;
        ind = op[2]; md = op[1:0]; a = op[4:3];
        sx = {{8{d[7]}}, d};
        case (md)
            2'd0: ea = {8'h00, d};
            2'd1: ea = m_pc + sx;
            2'd2: ea = m_ac[2] + sx;
            default: ea = m_ac[3] + sx;
        endcase
        e_trap = 1'b0; e_rs = 1'b0;
        if (op >= 8'o140) begin
            tag = "R2"; m_pc = m_pc + 1;
        end else if (op >= 8'o010 && op <= 8'o017 && md == 2'd0 &&
                     (ind ? d >= 8'o340 : d >= 8'o300)) begin
            tag = "R9"; e_trap = 1'b1;
        end else begin
            if (ind) ea = exp_mem[ea[9:0]];
            if (op <= 8'o007) begin
                tag = "R7"; m_pc = ea;
            end else if (op <= 8'o017) begin
                tag = "R8"; m_ac[3] = m_pc + 1; m_pc = ea;
            end else if (op <= 8'o037) begin
                tag = "R6";
                v = exp_mem[ea[9:0]] + ((op <= 8'o027) ? 16'h0001 : 16'hFFFF);
                exp_mem[ea[9:0]] = v;
                m_pc = m_pc + ((v == 0) ? 16'd2 : 16'd1);
            end else if (op <= 8'o077) begin
                tag = "R4"; m_ac[a] = exp_mem[ea[9:0]]; m_pc = m_pc + 1;
            end else begin
                tag = "R5"; exp_mem[ea[9:0]] = m_ac[a]; m_pc = m_pc + 1;
                e_rs = (md == 2'd1) && !ind;
            end
            if (ind) tag = {tag, "/R3"};
        end
        instr_valid = 1'b1; instr_op = op; instr_disp = d;
        @(negedge clk);
        instr_op = 8'o000; instr_disp = 8'h55;    // junk while busy (R12)
        n = 0;
        while (!done && n < 100) begin @(negedge clk); n++; end
        if (n >= 100) begin
            checks++; failures++;
            $display("FAIL R12 watchdog op=%o actual=busy expected=done", op);
        end
        g_trap = trap; g_rs = restart;
        if (e_trap) chk("R9", "trap_disp", {8'h00, trap_disp}, {8'h00, d});
        instr_valid = 1'b0;
        @(negedge clk);
        chk("R9", "trap", {15'd0, g_trap}, {15'd0, e_trap});
        chk("R10", "restart", {15'd0, g_rs}, {15'd0, e_rs});
        chk("R12", "done", {15'd0, done}, 16'd0);
        chk("R11", "idle req", {15'd0, mem_req}, 16'd0);
        chk(tag, "pc", pc, m_pc);
        chk(tag, "ac0", ac0, m_ac[0]);
        chk(tag, "ac1", ac1, m_ac[1]);
        chk(tag, "ac2", ac2, m_ac[2]);
        chk(tag, "ac3", ac3, m_ac[3]);
        mism = 0;
        for (int i = 0; i < MW; i++) if (mem[i] !== exp_mem[i]) mism++;
        chk(tag, "memory mismatches", W'(mism), '0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL R12 global watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
        $finish;
    end

    initial begin
        logic [7:0] dl [5];
        dl[0] = 8'h03; dl[1] = 8'h7E; dl[2] = 8'h81; dl[3] = 8'hC5; dl[4] = 8'hE7;
        for (int i = 0; i < MW; i++) set_word(i, W'(i * 16'h2F1B + 16'h0137));
        m_pc = '0;
        for (int i = 0; i < 4; i++) m_ac[i] = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "pc", pc, 0);
        chk("R1", "ac0", ac0, 0); chk("R1", "ac1", ac1, 0);
        chk("R1", "ac2", ac2, 0); chk("R1", "ac3", ac3, 0);
        chk("R1", "ready", {15'd0, instr_ready}, 16'd1);
        chk("R1", "req", {15'd0, mem_req}, 16'd0);
        chk("R1", "done", {15'd0, done}, 16'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // Directed cases
        set_word(20, 16'h0100); set_word(21, 16'h0200);
        set_word(10, 16'hFFFF); set_word(11, 16'h0001); set_word(12, 16'h0007);
        run(8'o060, 8'd20);          // R4 load AC2
        run(8'o070, 8'd21);          // R4 load AC3
        run(8'o020, 8'd10);          // R6 increment to zero: skip
        run(8'o030, 8'd11);          // R6 decrement to zero: skip
        run(8'o020, 8'd12);          // R6 no skip
        run(8'o010, 8'hC0);          // R9 direct trap lower edge
        run(8'o010, 8'hBF);          // R8 just below range
        run(8'o014, 8'hE0);          // R9 indirect trap lower edge
        run(8'o014, 8'hDF);          // R8/R3 just below range
        run(8'o101, 8'h02);          // R10 restart
        run(8'o105, 8'h02);          // R10 indirect: no restart
        run(8'o042, 8'hFE);          // R2 negative AC2-relative
        // Sweep of every opcode over boundary displacements and latencies
        for (int op = 0; op < 256; op++) begin
            for (int k = 0; k < 5; k++) begin
                lat = (op + k) % 3;
                run(8'(op), dl[k]);
            end
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule